// File: doc/BRIEF.md
# Timer Capture/Compare Channel Controller

This block is one channel of a free-running timer. It watches the timer count and an external pin. Depending on a four-bit control word, the channel does one of the following:

- leaves the pin to the general-purpose port and presets its output level;
- records the count when the pin changes;
- acts on the pin when the count matches a stored value;
- works with a partner channel in buffered compare/PWM.

In buffered compare/PWM the channel borrows the partner's register and releases the partner's pin.

The counter, the bus, interrupts and the port logic are outside the block. The surrounding timer supplies the count, a run enable and an overflow pulse. It writes the control word and the two channel registers through plain strobes. It receives the pin drive, the pin ownership indications and one event flag. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `tcc_channel`

## Requirements
- R1: After reset the control word is zero. `pin_owned`, `pin_oe`, `partner_free` and `flag` are 0, `pin_out` is 1 and `chan_q` is 0.
- R2: The control word is laid out as: bit 3 = buffered select (B), bit 2 = mode select (A), bits 1:0 = edge/level field (E). With E = 00 the channel neither owns nor drives the pin. The latched output level becomes the inverse of A: A = 1 gives 0 and A = 0 gives 1. That level shows on `pin_out` from the cycle after the write.
- R3: With B = 0, A = 0 and E nonzero, the pin is synchronized through two flops and a capture occurs on the selected transitions: E = 01 rising only, E = 10 falling only, E = 11 both. The capture is seen three clock edges after the pin changes.
- R4: A capture copies the count into `chan_q` and sets `flag` on the same edge. `flag_clr` clears `flag`. An event in the same cycle as `flag_clr` keeps `flag` set.
- R5: With B = 0, A = 1 and `cnt_run` high, a count equal to `chan_q` sets `flag`. The same edge changes the output according to E: 01 toggles it, 10 clears it, 11 sets it.
- R6: With E = 00 and A or B set, a match while running still sets `flag`, but the pin stays with the port and the output keeps its preset level.
- R7: While `cnt_run` is high, writes leave bits 3:2 of the control word unchanged, while bits 1:0 are still accepted.
- R8: `pin_oe` is 1 only in compare modes with E nonzero. In capture the pin is owned with `pin_oe` = 0.
- R9: With B = 1, `partner_free` is 1 and compares use an active value. At each `cnt_ovf` that value is loaded from whichever of the two registers was written last. Writes in between have no effect on the pin until that overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Current timer count |
| cnt_run | input | 1 | Counter run enable |
| cnt_ovf | input | 1 | One-cycle counter overflow pulse |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word {B, A, E[1:0]} |
| reg_wr | input | 1 | Channel register write strobe |
| reg_sel | input | 1 | 0 = own register, 1 = partner register |
| reg_wdata | input | CNT_W | Register write data |
| flag_clr | input | 1 | Write-one-to-clear for the event flag |
| pin_in | input | 1 | External pin level (asynchronous) |
| pin_out | output | 1 | Latched output level |
| pin_oe | output | 1 | Channel drives the pin |
| pin_owned | output | 1 | Pin taken from the port |
| partner_free | output | 1 | Partner pin released to the port |
| flag | output | 1 | Channel event flag |
| chan_q | output | CNT_W | Own channel register |
| partner_q | output | CNT_W | Partner channel register |

## Verification
The assertions rely on the counter's controller for two things. Mode bits only move while the counter is stopped. A change in `chan_q` therefore comes either from a register write or from a capture of the count present at that edge. The stimulus changes the mode with `cnt_run` low, except for one deliberate blocked write. It holds `cnt_val` steady around each capture and presents a matching count for exactly one cycle, so each compare fires once. Overflow pulses are given with a count that matches no register, so no compare event overlaps an overflow.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    CM_IDLE  = 3'd0,
    CM_SWCMP = 3'd1,
    CM_CAP   = 3'd2,
    CM_CMP   = 3'd3,
    CM_BUF   = 3'd4
  } chmode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } pinact_e;

  function automatic chmode_e decode_mode(input logic b, input logic a, input logic [1:0] e);
    if (e == 2'b00) return (a || b) ? CM_SWCMP : CM_IDLE;
    if (b)          return CM_BUF;
    if (a)          return CM_CMP;
    return CM_CAP;
  endfunction
endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  logic rise, fall;
  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
  assign hit  = (edge_sel[0] & rise) | (edge_sel[1] & fall);
endmodule

// File: rtl/tcc_decode.sv
module tcc_decode
  import tcc_pkg::*;
(
  input  logic [3:0] ctl,
  output chmode_e    mode,
  output logic       owned,
  output logic       drive,
  output logic       partner_rel
);
  always_comb begin
    mode        = decode_mode(ctl[3], ctl[2], ctl[1:0]);
    owned       = (mode == CM_CAP) || (mode == CM_CMP) || (mode == CM_BUF);
    drive       = (mode == CM_CMP) || (mode == CM_BUF);
    partner_rel = ctl[3];
  end
endmodule

// File: rtl/tcc_buffer.sv
module tcc_buffer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0,
  input  logic             wr1,
  input  logic             ovf,
  input  logic [CNT_W-1:0] reg0,
  input  logic [CNT_W-1:0] reg1,
  output logic [CNT_W-1:0] active
);
  logic last_one;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   last_one <= 1'b0;
    else if (wr1) last_one <= 1'b1;
    else if (wr0) last_one <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   active <= '0;
    else if (ovf) active <= last_one ? reg1 : reg0;
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chmode_e          mode,
  input  logic [1:0]       edge_f,
  input  logic             mode_a,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match,
  output logic             out_lvl
);
  logic cmp_mode;
  assign cmp_mode = (mode == CM_SWCMP) || (mode == CM_CMP) || (mode == CM_BUF);
  assign match    = cmp_mode && run && (cnt_val == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lvl <= 1'b1;
    end else if (edge_f == 2'b00) begin
      out_lvl <= ~mode_a;
    end else if (match) begin
      unique case (pinact_e'(edge_f))
        ACT_TOG:  out_lvl <= ~out_lvl;
        ACT_CLR:  out_lvl <= 1'b0;
        ACT_SET:  out_lvl <= 1'b1;
        default:  out_lvl <= out_lvl;
      endcase
    end
  end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_run,
  input  logic             cnt_ovf,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             flag_clr,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             pin_owned,
  output logic             partner_free,
  output logic             flag,
  output logic [CNT_W-1:0] chan_q,
  output logic [CNT_W-1:0] partner_q
);
  logic [3:0]       ctl_q;
  chmode_e          mode;
  logic             pin_hit, cap_hit, cmp_hit;
  logic             wr_own, wr_partner;
  logic [CNT_W-1:0] buf_active, cmp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q[1:0] <= ctl_wdata[1:0];
      if (!cnt_run) ctl_q[3:2] <= ctl_wdata[3:2];
    end
  end

  tcc_decode u_dec (
    .ctl         (ctl_q),
    .mode        (mode),
    .owned       (pin_owned),
    .drive       (pin_oe),
    .partner_rel (partner_free)
  );

  tcc_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .edge_sel (ctl_q[1:0]),
    .hit      (pin_hit)
  );
  assign cap_hit = pin_hit && (mode == CM_CAP);

  assign wr_own     = reg_wr && !reg_sel;
  assign wr_partner = reg_wr &&  reg_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       chan_q <= '0;
    else if (cap_hit) chan_q <= cnt_val;
    else if (wr_own)  chan_q <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          partner_q <= '0;
    else if (wr_partner) partner_q <= reg_wdata;

  tcc_buffer #(.CNT_W(CNT_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr0    (wr_own),
    .wr1    (wr_partner),
    .ovf    (cnt_ovf),
    .reg0   (chan_q),
    .reg1   (partner_q),
    .active (buf_active)
  );
  assign cmp_val = ctl_q[3] ? buf_active : chan_q;

  tcc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .edge_f  (ctl_q[1:0]),
    .mode_a  (ctl_q[2]),
    .run     (cnt_run),
    .cnt_val (cnt_val),
    .cmp_val (cmp_val),
    .match   (cmp_hit),
    .out_lvl (pin_out)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 flag <= 1'b0;
    else if (cap_hit | cmp_hit) flag <= 1'b1;
    else if (flag_clr)          flag <= 1'b0;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_run,
  input logic [CNT_W-1:0] cnt_val,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic             flag_clr,
  input logic [3:0]       ctl_q,
  input logic             pin_oe,
  input logic             pin_owned,
  input logic             flag,
  input logic [CNT_W-1:0] chan_q
);
  // R8
  oe_needs_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> pin_owned);

  // R2
  port_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] == 2'b00) |-> (!pin_owned && !pin_oe));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_run |=> $stable(ctl_q[3:2]));

  // R4
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));

  // R4
  cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(chan_q) && !$past(reg_wr && !reg_sel)) |-> (chan_q == $past(cnt_val)));

  // R1
  always_comb
    if (!rst_n) reset_state_chk: assert (ctl_q == 4'b0000);
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_run   (cnt_run),
  .cnt_val   (cnt_val),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .flag_clr  (flag_clr),
  .ctl_q     (ctl_q),
  .pin_oe    (pin_oe),
  .pin_owned (pin_owned),
  .flag      (flag),
  .chan_q    (chan_q)
);

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cnt_run = 1'b0, cnt_ovf = 1'b0;
  logic         ctl_wr = 1'b0;
  logic [3:0]   ctl_wdata = '0;
  logic         reg_wr = 1'b0, reg_sel = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic         flag_clr = 1'b0, pin_in = 1'b0;
  logic         pin_out, pin_oe, pin_owned, partner_free, flag;
  logic [W-1:0] chan_q, partner_q;

  always #10 clk = ~clk;

  tcc_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_run(cnt_run), .cnt_ovf(cnt_ovf),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .flag_clr(flag_clr), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_owned(pin_owned), .partner_free(partner_free), .flag(flag),
    .chan_q(chan_q), .partner_q(partner_q)
  );

  typedef enum int {S_OUT, S_OE, S_OWN, S_PFREE, S_FLAG, S_CHAN} sig_e;
  typedef struct { sig_e sig; int val; string req; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic int probe(sig_e s);
    case (s)
      S_OUT:   return int'(pin_out);
      S_OE:    return int'(pin_oe);
      S_OWN:   return int'(pin_owned);
      S_PFREE: return int'(partner_free);
      S_FLAG:  return int'(flag);
      default: return int'(chan_q);
    endcase
  endfunction

  task automatic expect_val(sig_e s, int v, string req);
    exp_t e;
    e.sig = s; e.val = v; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops every queued expectation and compares with the ports
  task automatic monitor();
    while (exp_q.size() > 0) begin
      exp_t e;
      int act;
      e = exp_q.pop_front();
      act = probe(e.sig);
      n_chk++;
      if (act !== e.val) begin
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d", e.req, e.sig.name(), act, e.val);
      end
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(logic [3:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; tick(1); ctl_wr = 1'b0;
  endtask

  task automatic wr_reg(logic sel, int v);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = W'(v); tick(1); reg_wr = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic pulse_cnt(int v, int idle);
    cnt_val = W'(v); tick(1); cnt_val = W'(idle); tick(1);
  endtask

  task automatic ovf_pulse();
    cnt_val = W'(1); cnt_ovf = 1'b1; tick(1); cnt_ovf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    expect_val(S_OUT, 1, "R1"); expect_val(S_OE, 0, "R1"); expect_val(S_OWN, 0, "R1");
    expect_val(S_PFREE, 0, "R1"); expect_val(S_FLAG, 0, "R1"); expect_val(S_CHAN, 0, "R1");
    monitor();
    rst_n = 1'b1; tick(2);

    // R2 preset level from A with E = 00
    wr_ctl(4'b0100); tick(1);
    expect_val(S_OUT, 0, "R2"); expect_val(S_OWN, 0, "R2"); expect_val(S_OE, 0, "R2");
    monitor();
    wr_ctl(4'b0000); tick(1);
    expect_val(S_OUT, 1, "R2"); monitor();

    // R3 rising only
    wr_ctl(4'b0001); cnt_val = 100; tick(2);
    expect_val(S_OWN, 1, "R8"); expect_val(S_OE, 0, "R8"); monitor();
    pin_in = 1'b1; tick(3);
    expect_val(S_FLAG, 1, "R4"); expect_val(S_CHAN, 100, "R3"); monitor();
    clr_flag();
    expect_val(S_FLAG, 0, "R4"); monitor();
    cnt_val = 200; pin_in = 1'b0; tick(4);
    expect_val(S_FLAG, 0, "R3"); expect_val(S_CHAN, 100, "R3"); monitor();

    // R3 falling only
    wr_ctl(4'b0010); cnt_val = 300; pin_in = 1'b1; tick(4);
    expect_val(S_FLAG, 0, "R3"); monitor();
    pin_in = 1'b0; tick(3);
    expect_val(S_FLAG, 1, "R3"); expect_val(S_CHAN, 300, "R3"); monitor();
    clr_flag();

    // R3 both edges
    wr_ctl(4'b0011); cnt_val = 400; pin_in = 1'b1; tick(3);
    expect_val(S_CHAN, 400, "R3"); monitor();
    clr_flag();
    cnt_val = 500; pin_in = 1'b0; tick(3);
    expect_val(S_CHAN, 500, "R3"); expect_val(S_FLAG, 1, "R3"); monitor();
    clr_flag();

    // R5 unbuffered compare actions
    cnt_val = 51;
    wr_ctl(4'b0100); tick(1);
    wr_ctl(4'b0111); wr_reg(1'b0, 50);
    expect_val(S_OUT, 0, "R5"); expect_val(S_OE, 1, "R8"); monitor();
    cnt_run = 1'b1; tick(1);
    pulse_cnt(50, 51);
    expect_val(S_OUT, 1, "R5"); expect_val(S_FLAG, 1, "R5"); monitor();
    clr_flag();
    wr_ctl(4'b0110);
    pulse_cnt(50, 51);
    expect_val(S_OUT, 0, "R5"); monitor();
    wr_ctl(4'b0101);
    pulse_cnt(50, 51);
    expect_val(S_OUT, 1, "R5"); monitor();
    pulse_cnt(50, 51);
    expect_val(S_OUT, 0, "R5"); monitor();
    clr_flag();

    // R6 software compare with E = 00
    wr_ctl(4'b0100); tick(1);
    pulse_cnt(50, 51);
    expect_val(S_FLAG, 1, "R6"); expect_val(S_OUT, 0, "R6"); expect_val(S_OWN, 0, "R6");
    monitor();
    clr_flag();

    // R7 mode bits blocked while running
    wr_ctl(4'b1101); tick(1);
    expect_val(S_PFREE, 0, "R7"); expect_val(S_OE, 1, "R7"); monitor();

    // R9 buffered compare
    cnt_run = 1'b0; cnt_val = 5;
    wr_ctl(4'b1101);
    expect_val(S_PFREE, 1, "R9"); expect_val(S_OWN, 1, "R9"); monitor();
    wr_reg(1'b0, 70);
    cnt_run = 1'b1;
    pulse_cnt(70, 5);
    expect_val(S_OUT, 0, "R9"); monitor();
    ovf_pulse(); cnt_val = 5; tick(1);
    pulse_cnt(70, 5);
    expect_val(S_OUT, 1, "R9"); monitor();
    wr_reg(1'b1, 90);
    pulse_cnt(90, 5);
    expect_val(S_OUT, 1, "R9"); monitor();
    ovf_pulse(); cnt_val = 5; tick(1);
    pulse_cnt(70, 5);
    expect_val(S_OUT, 1, "R9"); monitor();
    pulse_cnt(90, 5);
    expect_val(S_OUT, 0, "R9"); monitor();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule